// File: doc/BRIEF.md
# Descriptor Ring Index Controller

This block keeps the bookkeeping for two circular descriptor rings that feed a memory copy engine. One ring is the source ring, where software queues buffers to be sent. The other is the destination ring, where software posts empty buffers to be filled. Software programs each ring's base address, entry count, write index and watermark thresholds through a 32-bit register port. The block keeps the hardware read index of each ring and moves it forward by one entry for each completion pulse from the datapath.

From the two indices of each ring the block derives its occupancy. It raises latched interrupt status when an occupancy crosses a threshold, when a copy completes, and when software tries to overrun a full ring. A single interrupt line combines all enabled status bits. A halt command freezes both read indices and reports, through a status bit, the moment the datapath has gone idle.

Each descriptor is 8 bytes, so ring base addresses are always 8-byte aligned. Descriptor fetch, data movement and bus mastering are done elsewhere.

Top module: `ring_idx_ctrl`

## Requirements
- R1: Ring base registers (source 0x00, destination 0x08) store 32 bits with bits 2:0 forced to zero, because every descriptor is 8 bytes long.
- R2: A ring's entry count is set at 0x04 (source) or 0x0C (destination) and must be a power of two. A written write index (source 0x3C, destination 0x40) is stored as the value AND (count - 1) and reads back from the same offset.
- R3: A completion pulse (src_done, dst_done) advances that ring's read index to (index + 1) AND (count - 1) only when the occupancy (write - read) AND (count - 1) is nonzero. The read indices read back at 0x44 (source) and 0x48 (destination).
- R4: A write-index write that changes the index is ignored when the ring is full (occupancy = count - 1) or when the new index equals the read index. Such a write sets error status bit 5 (source) or bit 6 (destination) at 0x38.
- R5: Watermark registers (source 0x4C, destination 0x50) hold the low threshold in bits 31:16 and the high threshold in bits 15:0, and both reset to zero.
- R6: Host status at 0x30 latches bit 1 or bit 3 when the source or destination occupancy becomes greater than its high threshold. It latches bit 2 or bit 4 when that occupancy becomes less than its low threshold. A bit is set only on the cycle the condition turns true.
- R7: Host status bit 0 latches whenever either ring accepts a completion pulse.
- R8: Status bits at 0x30 and 0x38 are cleared by writing 1 to them. A set event in the same cycle wins over the clear.
- R9: The registered irq output is high one cycle after any bit of (host status AND host enable at 0x2C, bits 4:0) or (error status AND error enable at 0x34, bits 10:5) is set.
- R10: Writing 1 to bit 0 of the command register 0x18 requests a halt, and completion pulses are then ignored. Bit 3 of 0x18 reads 1 one cycle after the request is present with xfer_active low, and returns to 0 once the request is cleared.
- R11: The control register 0x10 resets to 0x00000080 and keeps only bits 18:0 of a write: maximum length in 15:0, source swap in 16, destination swap in 17.
- R12: reg_rdata is registered and shows the register at reg_addr one cycle later. Unmapped offsets and the unused error bits 10:7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| src_done | input | 1 | Source ring entry consumed by the datapath |
| dst_done | input | 1 | Destination ring entry filled by the datapath |
| xfer_active | input | 1 | Datapath has a transfer in flight |
| irq | output | 1 | Combined interrupt, registered |

## Verification
On every cycle the assertions check three things: a rejected index write leaves the write index unchanged, a pending halt freezes both read indices, and a written-one clear with no competing set empties the status bits. They also check that halt status never outlives the request and that irq stays low while all enables are zero. The bench scenarios show the value-level behaviour: wrap of indices under different ring sizes, the exact occupancy at which a watermark latches, both forms of overflow rejection, and the ordering of halt status against xfer_active.

// File: rtl/ring_idx_pkg.sv
package ring_idx_pkg;
  localparam logic [7:0] A_SRC_BASE = 8'h00;
  localparam logic [7:0] A_SRC_SIZE = 8'h04;
  localparam logic [7:0] A_DST_BASE = 8'h08;
  localparam logic [7:0] A_DST_SIZE = 8'h0C;
  localparam logic [7:0] A_CTRL     = 8'h10;
  localparam logic [7:0] A_CMD      = 8'h18;
  localparam logic [7:0] A_HOST_EN  = 8'h2C;
  localparam logic [7:0] A_HOST_ST  = 8'h30;
  localparam logic [7:0] A_ERR_EN   = 8'h34;
  localparam logic [7:0] A_ERR_ST   = 8'h38;
  localparam logic [7:0] A_SRC_WR   = 8'h3C;
  localparam logic [7:0] A_DST_WR   = 8'h40;
  localparam logic [7:0] A_SRC_RD   = 8'h44;
  localparam logic [7:0] A_DST_RD   = 8'h48;
  localparam logic [7:0] A_SRC_WM   = 8'h4C;
  localparam logic [7:0] A_DST_WM   = 8'h50;

  localparam int HOST_W   = 5;
  localparam int ERR_LSB  = 5;
  localparam int ERR_W    = 6;
  localparam int CTRL_W   = 19;
  localparam logic [CTRL_W-1:0] CTRL_RST = 19'h00080;
  localparam int CMD_HALT_BIT = 0;
  localparam int CMD_STS_BIT  = 3;
  localparam int NRING = 2;
endpackage

// File: rtl/ring_evt_w1c.sv
module ring_evt_w1c #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] clr_eff;

  assign clr_eff = we_i ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_eff) | set_i;
  end

  assign stat_o = stat_q;

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_eff & ~set_i) != '0) |=> ((stat_q & $past(clr_eff & ~set_i)) == '0));
endmodule

// File: rtl/ring_track.sv
module ring_track #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      wdata,
  input  logic             we_base,
  input  logic             we_size,
  input  logic             we_wr,
  input  logic             we_wm,
  input  logic             done_i,
  input  logic             hold_i,
  output logic [31:0]      base_o,
  output logic [IDX_W:0]   size_o,
  output logic [IDX_W-1:0] wr_o,
  output logic [IDX_W-1:0] rd_o,
  output logic [31:0]      wm_o,
  output logic             accept_o,
  output logic             ovf_o,
  output logic             hi_set_o,
  output logic             lo_set_o
);
  logic [31:3]      base_q;
  logic [IDX_W:0]   size_q;
  logic [IDX_W-1:0] wr_q, rd_q, mask, occ, new_wr;
  logic [15:0]      lo_q, hi_q;
  logic             hi_c, lo_c, hi_d, lo_d, full, reject;

  assign mask   = size_q[IDX_W-1:0] - IDX_W'(1);
  assign occ    = (wr_q - rd_q) & mask;
  assign full   = (occ == mask);
  assign new_wr = wdata[IDX_W-1:0] & mask;
  assign reject = we_wr && (new_wr != wr_q) && (full || (new_wr == rd_q));
  assign accept_o = done_i && !hold_i && (occ != '0);
  assign hi_c = 32'(occ) > 32'(hi_q);
  assign lo_c = 32'(occ) < 32'(lo_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      hi_d   <= 1'b0;
      lo_d   <= 1'b0;
    end else begin
      if (we_base) base_q <= wdata[31:3];
      if (we_size) size_q <= wdata[IDX_W:0];
      if (we_wr && !reject) wr_q <= new_wr;
      if (accept_o) rd_q <= (rd_q + IDX_W'(1)) & mask;
      if (we_wm) {lo_q, hi_q} <= wdata;
      hi_d <= hi_c;
      lo_d <= lo_c;
    end
  end

  assign base_o   = {base_q, 3'b000};
  assign size_o   = size_q;
  assign wr_o     = wr_q;
  assign rd_o     = rd_q;
  assign wm_o     = {lo_q, hi_q};
  assign ovf_o    = reject;
  assign hi_set_o = hi_c & ~hi_d;
  assign lo_set_o = lo_c & ~lo_d;

  // R4
  rejected_write_chk: assert property (@(posedge clk) disable iff (rst)
    reject |=> (wr_q == $past(wr_q)));
  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (rd_q == $past(rd_q)));
  // R3
  empty_no_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && !we_size) |=> (rd_q == $past(rd_q)));
endmodule

// File: rtl/ring_idx_ctrl.sv
module ring_idx_ctrl #(
  parameter int IDX_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        src_done,
  input  logic        dst_done,
  input  logic        xfer_active,
  output logic        irq
);
  import ring_idx_pkg::*;

  logic [31:0]      base_a [NRING];
  logic [IDX_W:0]   size_a [NRING];
  logic [IDX_W-1:0] wr_a   [NRING];
  logic [IDX_W-1:0] rd_a   [NRING];
  logic [31:0]      wm_a   [NRING];
  logic [NRING-1:0] acc_v, ovf_v, hi_v, lo_v, done_v;

  logic [CTRL_W-1:0] ctrl_q;
  logic [HOST_W-1:0] host_ie_q, host_st;
  logic [ERR_W-1:0]  err_ie_q, err_st;
  logic              halt_req_q, halt_sts_q, irq_q;
  logic [31:0]       rd_mux;

  assign done_v = {dst_done, src_done};

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    localparam logic [7:0] AB = (g == 0) ? A_SRC_BASE : A_DST_BASE;
    localparam logic [7:0] AS = (g == 0) ? A_SRC_SIZE : A_DST_SIZE;
    localparam logic [7:0] AW = (g == 0) ? A_SRC_WR   : A_DST_WR;
    localparam logic [7:0] AM = (g == 0) ? A_SRC_WM   : A_DST_WM;
    ring_track #(.IDX_W(IDX_W)) i_track (
      .clk      (clk),
      .rst      (rst),
      .wdata    (reg_wdata),
      .we_base  (reg_wr && reg_addr == AB),
      .we_size  (reg_wr && reg_addr == AS),
      .we_wr    (reg_wr && reg_addr == AW),
      .we_wm    (reg_wr && reg_addr == AM),
      .done_i   (done_v[g]),
      .hold_i   (halt_req_q),
      .base_o   (base_a[g]),
      .size_o   (size_a[g]),
      .wr_o     (wr_a[g]),
      .rd_o     (rd_a[g]),
      .wm_o     (wm_a[g]),
      .accept_o (acc_v[g]),
      .ovf_o    (ovf_v[g]),
      .hi_set_o (hi_v[g]),
      .lo_set_o (lo_v[g])
    );
  end

  ring_evt_w1c #(.W(HOST_W)) i_host_st (
    .clk    (clk),
    .rst    (rst),
    .set_i  ({lo_v[1], hi_v[1], lo_v[0], hi_v[0], |acc_v}),
    .we_i   (reg_wr && reg_addr == A_HOST_ST),
    .clr_i  (reg_wdata[HOST_W-1:0]),
    .stat_o (host_st)
  );

  ring_evt_w1c #(.W(ERR_W)) i_err_st (
    .clk    (clk),
    .rst    (rst),
    .set_i  ({4'b0000, ovf_v[1], ovf_v[0]}),
    .we_i   (reg_wr && reg_addr == A_ERR_ST),
    .clr_i  (reg_wdata[ERR_LSB+ERR_W-1:ERR_LSB]),
    .stat_o (err_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= CTRL_RST;
      host_ie_q  <= '0;
      err_ie_q   <= '0;
      halt_req_q <= 1'b0;
      halt_sts_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL)    ctrl_q     <= reg_wdata[CTRL_W-1:0];
      if (reg_wr && reg_addr == A_HOST_EN) host_ie_q  <= reg_wdata[HOST_W-1:0];
      if (reg_wr && reg_addr == A_ERR_EN)  err_ie_q   <= reg_wdata[ERR_LSB+ERR_W-1:ERR_LSB];
      if (reg_wr && reg_addr == A_CMD)     halt_req_q <= reg_wdata[CMD_HALT_BIT];
      halt_sts_q <= halt_req_q & ~xfer_active;
      irq_q      <= |(host_st & host_ie_q) | |(err_st & err_ie_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_SRC_BASE: rd_mux = base_a[0];
      A_DST_BASE: rd_mux = base_a[1];
      A_SRC_SIZE: rd_mux = 32'(size_a[0]);
      A_DST_SIZE: rd_mux = 32'(size_a[1]);
      A_CTRL:     rd_mux = 32'(ctrl_q);
      A_CMD: begin
        rd_mux[CMD_HALT_BIT] = halt_req_q;
        rd_mux[CMD_STS_BIT]  = halt_sts_q;
      end
      A_HOST_EN:  rd_mux = 32'(host_ie_q);
      A_HOST_ST:  rd_mux = 32'(host_st);
      A_ERR_EN:   rd_mux = 32'(err_ie_q) << ERR_LSB;
      A_ERR_ST:   rd_mux = 32'(err_st) << ERR_LSB;
      A_SRC_WR:   rd_mux = 32'(wr_a[0]);
      A_DST_WR:   rd_mux = 32'(wr_a[1]);
      A_SRC_RD:   rd_mux = 32'(rd_a[0]);
      A_DST_RD:   rd_mux = 32'(rd_a[1]);
      A_SRC_WM:   rd_mux = wm_a[0];
      A_DST_WM:   rd_mux = wm_a[1];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign irq = irq_q;

  // R10
  halt_sts_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    !halt_req_q |=> !halt_sts_q);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (host_ie_q == '0 && err_ie_q == '0) |=> !irq);
endmodule

// File: tb/test_ring_idx_ctrl.sv
`timescale 1ns/1ps
module test_ring_idx_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_done = 1'b0;
  logic        dst_done = 1'b0;
  logic        xfer_active = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #2.5 clk = ~clk;

  ring_idx_ctrl i_ring_idx_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_done(src_done),
    .dst_done(dst_done), .xfer_active(xfer_active), .irq(irq)
  );

  task automatic note(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read and compares after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        rd_item_t it;
        #1;
        it = exp_q.pop_front();
        note(it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    rd_item_t it;
    @(negedge clk);
    reg_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic pulse(bit dst, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dst) dst_done = 1'b1; else src_done = 1'b1;
      @(negedge clk);
      dst_done = 1'b0; src_done = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(8'h10, 32'h0000_0080, "R11 ctrl reset");
    rd(8'h4C, 32'h0, "R5 src watermark reset");
    rd(8'h50, 32'h0, "R5 dst watermark reset");
    rd(8'h30, 32'h0, "R8 host status reset");
    rd(8'h18, 32'h0, "R10 cmd reset");
    note("R9 irq reset", 32'(irq), 32'h0);
    // R1 base alignment
    wr(8'h00, 32'h1234_5677);
    rd(8'h00, 32'h1234_5670, "R1 src base");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'hFFFF_FFF8, "R1 dst base");
    // R11 control mask
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0007_FFFF, "R11 ctrl mask");
    // sizes and watermarks
    wr(8'h04, 32'd8);
    wr(8'h0C, 32'd4);
    wr(8'h4C, 32'h0002_0005);
    rd(8'h4C, 32'h0002_0005, "R5 src watermark");
    rd(8'h30, 32'h04, "R6 src low latched at occ 0");
    wr(8'h30, 32'h04);
    rd(8'h30, 32'h00, "R8 w1c clear");
    // R6 high crossing
    wr(8'h3C, 32'd6);
    rd(8'h3C, 32'd6, "R2 src write index");
    rd(8'h30, 32'h02, "R6 src high latched");
    // R2 masking
    wr(8'h3C, 32'h0000_000F);
    rd(8'h3C, 32'd7, "R2 masked write index");
    // R4 full ring
    wr(8'h3C, 32'd1);
    rd(8'h3C, 32'd7, "R4 full write ignored");
    rd(8'h38, 32'h20, "R4 src overflow bit");
    note("R9 irq masked", 32'(irq), 32'h0);
    wr(8'h34, 32'h20);
    note("R9 irq from error", 32'(irq), 32'h1);
    wr(8'h38, 32'h20);
    note("R9 irq after clear", 32'(irq), 32'h0);
    // R3 / R7 completions
    pulse(1'b0, 3);
    rd(8'h44, 32'd3, "R3 src read index");
    rd(8'h30, 32'h03, "R7 copy complete");
    wr(8'h2C, 32'h01);
    note("R9 irq from host", 32'(irq), 32'h1);
    wr(8'h30, 32'h03);
    note("R9 irq host cleared", 32'(irq), 32'h0);
    pulse(1'b0, 5);
    rd(8'h44, 32'd7, "R3 empty ring stops");
    rd(8'h30, 32'h05, "R6 src low crossing");
    wr(8'h3C, 32'd2);
    pulse(1'b0, 1);
    rd(8'h44, 32'd0, "R3 read index wraps");
    // R4 new index equals read index
    wr(8'h3C, 32'd0);
    rd(8'h3C, 32'd2, "R4 index onto read ignored");
    // destination ring
    wr(8'h40, 32'd3);
    wr(8'h40, 32'd1);
    rd(8'h40, 32'd3, "R4 dst full write ignored");
    rd(8'h38, 32'h60, "R4 both overflow bits");
    pulse(1'b1, 1);
    rd(8'h48, 32'd1, "R3 dst read index");
    // R10 halt
    xfer_active = 1'b1;
    wr(8'h18, 32'h1);
    rd(8'h18, 32'h1, "R10 halt waits for idle");
    xfer_active = 1'b0;
    @(negedge clk);
    rd(8'h18, 32'h9, "R10 halt status");
    pulse(1'b0, 1);
    rd(8'h44, 32'd0, "R10 index frozen");
    wr(8'h18, 32'h0);
    rd(8'h18, 32'h0, "R10 halt released");
    pulse(1'b0, 1);
    rd(8'h44, 32'd1, "R3 advance after release");
    // R12
    rd(8'h7C, 32'h0, "R12 unmapped");
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, 32'h0000_07E0, "R12 error enable field");
    rd(8'h38, 32'h60, "R12 unused error bits zero");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    summary();
  end
endmodule